// File: doc/BRIEF.md
# Movable Window Chip-Select Decoder

This block takes a flat 32-bit address from a bus master and splits it into an address inside one memory or peripheral device, plus a one-hot chip-select vector for up to eight devices. In the extended modes, a size code sets the width of the per-device address window. The device-select field sits directly above that window, so the devices appear to software as one contiguous block of memory. Any address bits above the device field are dropped.

Three decode variants are supported. The legacy pack mode has a fixed 21-bit window and four chip selects. The extended storage mode has a movable window and memory on the low four chip selects. The extended mixed mode has a movable window and a three-bit device field: the lower half of its space goes to peripherals on the low four selects, and the upper half goes to memory on the high four.

The decode is combinational. All outputs are registered, so a request presented in one cycle shows up on the outputs after the next rising clock edge.

Top module: `mwin_cs_decode`

## Requirements
- R1: When `ext_mode`=0 (pack mode), `dev_addr` equals `addr[20:0]` zero-extended, `cs` selects the device `addr[22:21]` among bits 0 to 3, `periph` is 0, and `size_code` and `mixed` have no effect.
- R2: When `ext_mode`=1 and `size_code` is 1 to 13, the window width is W = 14 + `size_code`, and `dev_addr` equals `addr[W-1:0]` zero-extended to 28 bits.
- R3: When `ext_mode`=1, `mixed`=0 and `size_code` is 1 to 13, `cs` is one-hot at bit index `addr[W+1:W]` (bits 0 to 3 only), and `periph` is 0.
- R4: When `ext_mode`=1, `mixed`=1 and `size_code` is 1 to 13, `cs` is one-hot at bit index `addr[W+2:W]`. `periph` is 1 exactly when that index is 0 to 3.
- R5: In every mode, address bits above the device field have no effect on any output.
- R6: When `ext_mode`=1 and `size_code` is 0, 14 or 15, the window is 14 bits and only bit 0 of `cs` can be set. In this case `periph` equals `mixed`.
- R7: A cycle with `req_valid`=0 produces all-zero `cs`, `dev_addr` and `periph` one cycle later.
- R8: All outputs reflect the inputs of the previous rising edge. While `rst_n` is low, all outputs are zero.
- R9: `cs` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| addr | input | 32 | Flat address from the master |
| size_code | input | 4 | Window size code, W = 14 + code |
| ext_mode | input | 1 | 0 = pack mode, 1 = extended mode |
| mixed | input | 1 | Extended only: 1 = peripherals and memory share the selects |
| dev_addr | output | 28 | Address inside the selected device |
| cs | output | 8 | One-hot chip selects |
| periph | output | 1 | Selected device is a peripheral |

## Verification
Two decode rules can meet in one cycle. The first is the window and field placement: the three-bit mixed-mode field can sit at bits 29 down to 27. The second is the truncation of the address bits above that field. The bench provokes both at once with a random address in every cycle, including codes 12 and 13 with ones in the top bits. A behavioural model, written with shifts on integers, gives the expected `cs`, `dev_addr` and `periph`, and the bench compares the outputs one edge later. Directed cycles follow each other back to back, for example an idle cycle straight after a selecting one and a mode switch between two requests, to show that nothing carries over from one request to the next.

// File: rtl/mwin_cs_decode.sv
module mwin_cs_decode #(
  parameter int ADDR_W  = 32,
  parameter int DEV_AW  = 28,
  parameter int CS_N    = 8,
  parameter int CODE_W  = 4,
  parameter int BASE_W  = 14,
  parameter int PACK_W  = 21,
  parameter int CODE_HI = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CODE_W-1:0] size_code,
  input  logic              ext_mode,
  input  logic              mixed,
  output logic [DEV_AW-1:0] dev_addr,
  output logic [CS_N-1:0]   cs,
  output logic              periph
);
  localparam int WIN_W = $clog2(ADDR_W);
  localparam int SEL_W = $clog2(CS_N);

  logic             small_code;
  logic [WIN_W-1:0] win;
  logic [SEL_W-1:0] fld;
  logic [SEL_W-1:0] sel;
  logic [ADDR_W-1:0] mask;
  logic             periph_nx;

  assign small_code = (size_code == '0) || (size_code > CODE_W'(CODE_HI));

  always_comb begin
    if (!ext_mode)       win = WIN_W'(PACK_W);
    else if (small_code) win = WIN_W'(BASE_W);
    else                 win = WIN_W'(BASE_W) + WIN_W'(size_code);
  end

  assign fld  = SEL_W'(addr >> win);
  assign mask = (ADDR_W'(1) << win) - ADDR_W'(1);

  always_comb begin
    if (ext_mode && small_code) sel = '0;
    else if (ext_mode && mixed) sel = fld;
    else                        sel = {1'b0, fld[SEL_W-2:0]};
  end

  assign periph_nx = ext_mode && mixed && !sel[SEL_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n || !req_valid) begin
      cs       <= '0;
      dev_addr <= '0;
      periph   <= 1'b0;
    end else begin
      cs       <= CS_N'(1) << sel;
      dev_addr <= DEV_AW'(addr & mask);
      periph   <= periph_nx;
    end
  end

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs));

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (cs == '0 && dev_addr == '0 && !periph));

  p_pack_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ext_mode) |=> (cs[CS_N-1:CS_N/2] == '0 && !periph));

  p_ssd_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ext_mode && !mixed) |=> (cs[CS_N-1:CS_N/2] == '0 && !periph));

  p_small_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ext_mode && small_code) |=> (cs[CS_N-1:1] == '0));

  p_periph_side_r4: assert property (@(posedge clk) disable iff (!rst_n)
    periph |-> (cs[CS_N/2-1:0] != '0));

  p_valid_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> $onehot(cs));
endmodule

// File: tb/mwin_cs_decode_bench.sv
module mwin_cs_decode_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] addr = '0;
  logic [3:0]  size_code = '0;
  logic        ext_mode = 1'b0;
  logic        mixed = 1'b0;
  logic [27:0] dev_addr;
  logic [7:0]  cs;
  logic        periph;

  int total = 0;
  int bad = 0;
  logic [7:0]  exp_cs = '0;
  logic [27:0] exp_addr = '0;
  logic        exp_p = 1'b0;
  string       exp_tag = "R8";

  always #2 clk = ~clk;

  mwin_cs_decode u_mwin_cs_decode (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .addr(addr),
    .size_code(size_code), .ext_mode(ext_mode), .mixed(mixed),
    .dev_addr(dev_addr), .cs(cs), .periph(periph));

  task automatic check(input string tag);
    total++;
    if (cs !== exp_cs || dev_addr !== exp_addr || periph !== exp_p || !$onehot0(cs)) begin
      bad++;
      $display("FAIL %s(/R2/R5/R9): cs=%h addr=%h p=%b expected cs=%h addr=%h p=%b",
               tag, cs, dev_addr, periph, exp_cs, exp_addr, exp_p);
    end
  endtask

  // reference model: behavioural, from the requirements
  task automatic apply(input logic v, input logic [31:0] a, input logic [3:0] c,
                       input logic md, input logic m);
    longint w, idx, fa;
    fa = longint'(a);
    req_valid = v; addr = a; size_code = c; ext_mode = md; mixed = m;
    if (!v) begin
      exp_cs = 0; exp_addr = 0; exp_p = 0; exp_tag = "R7";
      return;
    end
    if (!md) begin
      w = 21; idx = (fa >> 21) % 4; exp_p = 0; exp_tag = "R1";
    end else if (c == 0 || c >= 14) begin
      w = 14; idx = 0; exp_p = m; exp_tag = "R6";
    end else begin
      w = 14 + longint'(c);
      if (m) begin idx = (fa >> w) % 8; exp_p = (idx < 4); exp_tag = "R4"; end
      else   begin idx = (fa >> w) % 4; exp_p = 0;         exp_tag = "R3"; end
    end
    exp_cs   = 8'(1 << idx);
    exp_addr = 28'(fa % (longint'(1) << w));
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [3:0] c,
                      input logic md, input logic m);
    string t;
    apply(v, a, c, md, m);
    t = exp_tag;
    @(negedge clk);
    check(t);
  endtask

  initial begin : watchdog
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R8: outputs zero during reset, even with a request present
    req_valid = 1'b1; addr = 32'hFFFF_FFFF; ext_mode = 1'b1; mixed = 1'b1; size_code = 4'd5;
    repeat (3) @(negedge clk);
    exp_cs = 0; exp_addr = 0; exp_p = 0;
    check("R8");
    rst_n = 1'b1;
    // R1 pack: code and mixed ignored, upper bits truncated (R5)
    step(1, 32'hFF40_1234, 4'd13, 0, 1);
    step(1, 32'h0060_0001, 4'd0, 0, 0);
    step(1, 32'h001F_FFFF, 4'd7, 0, 1);
    // R7 idle right after a select
    step(0, 32'h0060_0001, 4'd3, 1, 1);
    // R3 SSD code 6: field at A20
    step(1, 32'h0023_4567, 4'd6, 1, 0);
    // R3 code 1: A15 upward, bits above truncated (R5)
    step(1, 32'hFFFF_8ABC, 4'd1, 1, 0);
    // R4 mixed code 13: field A29..A27
    step(1, 32'h3800_0005, 4'd13, 1, 1);
    step(1, 32'h1000_0000, 4'd13, 1, 1);
    step(1, 32'hC000_0000, 4'd13, 1, 1);
    // R6 codes 0, 14, 15
    step(1, 32'hFFFF_FFFF, 4'd0, 1, 0);
    step(1, 32'hFFFF_FFFF, 4'd14, 1, 1);
    step(1, 32'h0FFF_FFFF, 4'd15, 1, 0);
    // mode switch back to back
    step(1, 32'h0040_0000, 4'd2, 0, 0);
    step(1, 32'h0040_0000, 4'd2, 1, 1);
    // random traffic, all rules interleaved
    for (int i = 0; i < 3000; i++)
      step(($urandom % 8) != 0, $urandom, 4'($urandom), 1'($urandom), 1'($urandom));
    // R8 reset mid-stream clears outputs
    rst_n = 1'b0;
    apply(1, 32'h0060_0000, 4'd0, 0, 0);
    @(negedge clk);
    exp_cs = 0; exp_addr = 0; exp_p = 0;
    check("R8");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule